// File: doc/BRIEF.md
# Cycle-Stealing Bus Arbiter

This block divides a single memory bus between a video fetch engine and a CPU. Each bus cycle has two phases. The video side always uses the first phase, when the generated phase clock `phi` is low. The CPU uses the second phase, when `phi` is high, as long as its address enable `aec` is high.

When the video side needs whole cycles to itself, for a burst of row-pointer fetches or for the data of one display object, the schedule raises `ptr_req` or `obj_req`. The arbiter then lowers the bus-available line `ba` for a fixed warning period of three cycles. During that period the CPU may still finish writes, but its first read stalls it. After the warning, `aec` stays low through the high phase, so the video side takes both phases of every stolen cycle.

A requested window that is still open absorbs any new request. Five DRAM refresh slots are placed in the video phases of every raster line. A per-phase owner tag shows who holds the bus, so the bus sequence can be compared with a scoreboard. All interfaces are plain control pins. The block has no data path, so there is no valid/ready handshake and no back-pressure.

Top module: `cycsteal_arbiter`

## Requirements
- R1: While `phi` is low, `aec` is low, `cpu_stall` is low and `owner` is 0 (video) or 3 (refresh). The owner encoding is 0 video, 1 CPU, 2 CPU writes only, 3 refresh.
- R2: While `ba` is high, `aec` equals `phi`, `cpu_stall` is low, and `owner` is 1 in the high phase.
- R3: A request sampled at the clock edge that ends the high phase of cycle k drives `ba` low from the start of cycle k+1. Cycles k+1 to k+3 are warning cycles, in which `aec` is still high in the high phase. Stolen cycles start at cycle k+4, with `aec` low in both phases.
- R4: A `ptr_req` steals exactly 40 consecutive cycles.
- R5: An `obj_req` steals exactly 2 cycles. When `ptr_req` and `obj_req` arrive on the same edge, the window steals 42 cycles.
- R6: In a warning cycle, `owner` is 2 in the high phase and a write (`cpu_rnw`=0) leaves `cpu_stall` low. A read (`cpu_rnw`=1) raises `cpu_stall` with `aec` still high. Once a read has been seen, `cpu_stall` stays high in every later high phase until `ba` returns high.
- R7: In the high phase of a stolen cycle, `cpu_stall` is high and `owner` is 0.
- R8: `ba`, `aec` and the stall all release in the first cycle after the last stolen cycle. `ba` changes only at the start of a cycle.
- R9: A request that arrives while `ba` is low adds its cycles to the open window. No new warning is started and `ba` does not rise between the two.
- R10: A line is 63 cycles long and the first cycle after reset is cycle 0. `refresh` is high, with `owner` 3, in the low phase of cycles 11 to 15, giving exactly 5 refresh slots per line.
- R11: During reset, `phi` is low, `ba` is high, `aec` is low, `cpu_stall` is low and `owner` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-rate clock; each edge starts a new phase |
| rst | input | 1 | Synchronous reset, active high |
| ptr_req | input | 1 | Row-pointer burst request, sampled at the end of a high phase |
| obj_req | input | 1 | Object data fetch request, sampled at the end of a high phase |
| cpu_rnw | input | 1 | CPU access direction: 1 read, 0 write |
| phi | output | 1 | Phase clock: low is the video phase, high is the CPU phase |
| ba | output | 1 | Bus-available warning line, low during warning and stolen cycles |
| aec | output | 1 | CPU address enable |
| cpu_stall | output | 1 | CPU must hold its current access |
| refresh | output | 1 | This phase is a DRAM refresh slot |
| owner | output | 2 | Owner tag of the current phase |

## Verification
If the stolen-cycle counter holds a wrong value, the error shows at the ports: `ba` rises too early or too late, and `aec` disagrees with the model in the high phase at the end of that same window. A wrong warning count shows within four cycles of the request, as an `aec` drop that comes too early or too late. A lost sticky-read state shows in the next high phase of the warning, as `cpu_stall` falling during a write. A wrong line-counter value shifts the refresh slots, and the error appears in the low phase of cycle 11 at the latest. The reference model is compared with the design on every phase, so each of these faults is reported in the phase where it first appears.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_VIDEO   = 2'd0,
    OWN_CPU     = 2'd1,
    OWN_CPU_WR  = 2'd2,
    OWN_REFRESH = 2'd3
  } owner_e;
endpackage

// File: rtl/phase_timer.sv
// Generates the two-phase cycle, counts cycles within a raster line and
// marks the refresh slots.
module phase_timer #(
  parameter int LINE_CYCLES = 63,
  parameter int REF_START   = 11,
  parameter int REF_SLOTS   = 5
) (
  input  logic clk,
  input  logic rst,
  output logic phi,
  output logic cyc_end,
  output logic refresh
);
  localparam int CYC_W = $clog2(LINE_CYCLES);
  localparam logic [CYC_W-1:0] LAST   = CYC_W'(LINE_CYCLES - 1);
  localparam logic [CYC_W-1:0] REF_LO = CYC_W'(REF_START);
  localparam logic [CYC_W-1:0] REF_HI = CYC_W'(REF_START + REF_SLOTS - 1);

  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi <= 1'b0;
      cyc <= '0;
    end else begin
      phi <= ~phi;
      if (phi) cyc <= (cyc == LAST) ? '0 : cyc + 1'b1;
    end
  end

  assign cyc_end = phi;
  assign refresh = ~phi && (cyc >= REF_LO) && (cyc <= REF_HI);
endmodule

// File: rtl/steal_seq.sv
// Tracks owed stolen cycles, the warning period and the sticky read stall.
module steal_seq #(
  parameter int WARN_CYCLES = 3,
  parameter int PTR_CYCLES  = 40,
  parameter int OBJ_CYCLES  = 2,
  parameter int LINE_CYCLES = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic add_ptr,
  input  logic add_obj,
  input  logic cpu_rnw,
  output logic ba,
  output logic steal,
  output logic halted
);
  localparam int OWED_W = $clog2(2 * LINE_CYCLES + 1);
  localparam int WARN_W = $clog2(WARN_CYCLES + 1);
  localparam logic [OWED_W:0]   PTR_ADD = (OWED_W + 1)'(PTR_CYCLES);
  localparam logic [OWED_W:0]   OBJ_ADD = (OWED_W + 1)'(OBJ_CYCLES);
  localparam logic [OWED_W:0]   OWED_MAX = {1'b0, {OWED_W{1'b1}}};
  localparam logic [WARN_W-1:0] WARN_N = WARN_W'(WARN_CYCLES);

  logic [OWED_W-1:0] owed;
  logic [WARN_W-1:0] warn;
  logic [OWED_W:0]   tot_raw;
  logic [OWED_W-1:0] tot;

  always_comb begin
    tot_raw = {1'b0, owed} + (add_ptr ? PTR_ADD : '0) + (add_obj ? OBJ_ADD : '0);
    tot     = (tot_raw > OWED_MAX) ? OWED_MAX[OWED_W-1:0] : tot_raw[OWED_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ba     <= 1'b1;
      steal  <= 1'b0;
      owed   <= '0;
      warn   <= '0;
      halted <= 1'b0;
    end else if (step) begin
      if (tot == '0) begin
        ba     <= 1'b1;
        steal  <= 1'b0;
        owed   <= '0;
        warn   <= '0;
        halted <= 1'b0;
      end else begin
        ba     <= 1'b0;
        halted <= halted | (~ba & cpu_rnw);
        if (warn < WARN_N) begin
          steal <= 1'b0;
          warn  <= warn + 1'b1;
          owed  <= tot;
        end else begin
          steal <= 1'b1;
          owed  <= tot - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cycsteal_arbiter.sv
module cycsteal_arbiter
  import arb_pkg::*;
#(
  parameter int LINE_CYCLES = 63,
  parameter int WARN_CYCLES = 3,
  parameter int PTR_CYCLES  = 40,
  parameter int OBJ_CYCLES  = 2,
  parameter int REF_START   = 11,
  parameter int REF_SLOTS   = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ptr_req,
  input  logic       obj_req,
  input  logic       cpu_rnw,
  output logic       phi,
  output logic       ba,
  output logic       aec,
  output logic       cpu_stall,
  output logic       refresh,
  output logic [1:0] owner
);
  logic cyc_end, steal, halted;
  owner_e own;

  phase_timer #(
    .LINE_CYCLES(LINE_CYCLES), .REF_START(REF_START), .REF_SLOTS(REF_SLOTS)
  ) u_timer (
    .clk(clk), .rst(rst), .phi(phi), .cyc_end(cyc_end), .refresh(refresh)
  );

  steal_seq #(
    .WARN_CYCLES(WARN_CYCLES), .PTR_CYCLES(PTR_CYCLES),
    .OBJ_CYCLES(OBJ_CYCLES), .LINE_CYCLES(LINE_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .step(cyc_end), .add_ptr(ptr_req), .add_obj(obj_req),
    .cpu_rnw(cpu_rnw), .ba(ba), .steal(steal), .halted(halted)
  );

  assign aec       = phi & ~steal;
  assign cpu_stall = phi & (steal | (~ba & (halted | cpu_rnw)));

  always_comb begin
    if (!phi)      own = refresh ? OWN_REFRESH : OWN_VIDEO;
    else if (steal) own = OWN_VIDEO;
    else if (!ba)   own = OWN_CPU_WR;
    else            own = OWN_CPU;
  end

  assign owner = own;
endmodule

// File: rtl/cycsteal_arbiter_chk.sv
module cycsteal_arbiter_chk
  import arb_pkg::*;
#(
  parameter int WARN_CYCLES = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       cpu_rnw,
  input logic       phi,
  input logic       ba,
  input logic       aec,
  input logic       cpu_stall,
  input logic       refresh,
  input logic [1:0] owner
);
  localparam int LOW_W = $clog2(WARN_CYCLES + 2);
  localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(WARN_CYCLES + 1);
  localparam logic [LOW_W-1:0] WARN_N  = LOW_W'(WARN_CYCLES);

  // completed bus cycles since ba fell, saturating
  logic [LOW_W-1:0] low_cyc;
  always_ff @(posedge clk) begin
    if (rst || ba) low_cyc <= '0;
    else if (phi && low_cyc != LOW_SAT) low_cyc <= low_cyc + 1'b1;
  end

  p_video_phase_r1: assert property (@(posedge clk) disable iff (rst)
    !phi |-> (!aec && !cpu_stall && (owner == OWN_VIDEO || owner == OWN_REFRESH)));
  p_aec_follows_phi_r2: assert property (@(posedge clk) disable iff (rst)
    ba |-> (aec == phi && !cpu_stall));
  p_warn_before_steal_r3: assert property (@(posedge clk) disable iff (rst)
    (phi && !aec) |-> (low_cyc >= WARN_N));
  p_steal_after_warn_r3: assert property (@(posedge clk) disable iff (rst)
    (phi && !ba && low_cyc >= WARN_N) |-> !aec);
  p_read_stalls_r6: assert property (@(posedge clk) disable iff (rst)
    (phi && !ba && cpu_rnw) |-> cpu_stall);
  p_steal_owner_r7: assert property (@(posedge clk) disable iff (rst)
    (phi && !aec) |-> (cpu_stall && owner == OWN_VIDEO));
  p_ba_at_cycle_start_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(ba) |-> !phi);
  p_refresh_slot_r10: assert property (@(posedge clk) disable iff (rst)
    refresh |-> (!phi && owner == OWN_REFRESH));
endmodule

bind cycsteal_arbiter cycsteal_arbiter_chk #(.WARN_CYCLES(WARN_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cpu_rnw(cpu_rnw), .phi(phi), .ba(ba), .aec(aec),
  .cpu_stall(cpu_stall), .refresh(refresh), .owner(owner)
);

// File: tb/cycsteal_arbiter_test.sv
module cycsteal_arbiter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ptr_req = 1'b0, obj_req = 1'b0, cpu_rnw = 1'b1;
  logic phi, ba, aec, cpu_stall, refresh;
  logic [1:0] owner;

  always #5 clk = ~clk;

  cycsteal_arbiter uut (
    .clk(clk), .rst(rst), .ptr_req(ptr_req), .obj_req(obj_req), .cpu_rnw(cpu_rnw),
    .phi(phi), .ba(ba), .aec(aec), .cpu_stall(cpu_stall), .refresh(refresh),
    .owner(owner)
  );

  int checks = 0, errors = 0;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: owed cycles, cycles since ba fell, read-seen flag
  int m_phi, m_cyc, m_ba, m_steal, m_owed, m_since, m_read, m_need;
  always @(posedge clk) begin
    if (rst) begin
      m_phi = 0; m_cyc = 0; m_ba = 1; m_steal = 0; m_owed = 0; m_since = 0; m_read = 0;
    end else begin
      if (m_phi == 1) begin
        m_need = m_owed + (ptr_req ? 40 : 0) + (obj_req ? 2 : 0);
        m_cyc = (m_cyc + 1) % 63;
        if (m_need == 0) begin
          m_ba = 1; m_steal = 0; m_owed = 0; m_since = 0; m_read = 0;
        end else begin
          if (m_ba == 0 && cpu_rnw) m_read = 1;
          m_ba = 0;
          if (m_since < 3) begin
            m_since++; m_steal = 0; m_owed = m_need;
          end else begin
            m_steal = 1; m_owed = m_need - 1;
          end
        end
      end
      m_phi = 1 - m_phi;
    end
  end

  int ba_falls = 0, ref_seen = 0;
  logic ba_prev = 1'b1;
  always @(negedge clk) begin
    int e_aec, e_stall, e_own, e_ref;
    if (!rst) begin
      e_ref   = (m_phi == 0 && m_cyc >= 11 && m_cyc <= 15) ? 1 : 0;
      e_aec   = (m_phi == 1 && m_steal == 0) ? 1 : 0;
      e_stall = (m_phi == 1 && (m_steal == 1 || (m_ba == 0 && (m_read == 1 || cpu_rnw)))) ? 1 : 0;
      if (m_phi == 0)       e_own = e_ref ? 3 : 0;
      else if (m_steal)     e_own = 0;
      else if (m_ba == 0)   e_own = 2;
      else                  e_own = 1;
      check("R8", int'(phi), m_phi, "phi");
      check("R3", int'(ba), m_ba, "ba");
      check("R7", int'(aec), e_aec, "aec");
      check("R6", int'(cpu_stall), e_stall, "cpu_stall");
      check("R1", int'(owner), e_own, "owner");
      check("R10", int'(refresh), e_ref, "refresh");
      if (ba_prev && !ba) ba_falls++;
      if (refresh) ref_seen++;
      ba_prev = ba;
    end
  end

  logic s_ba, s_aec, s_stall;
  logic [1:0] s_own;

  // one bus cycle: drive in the high phase, sample, then clear requests
  task automatic cyc(input bit p, input bit o, input bit rw);
    @(negedge clk);
    while (phi !== 1'b1) @(negedge clk);
    #1 ptr_req = p; obj_req = o; cpu_rnw = rw;
    #1 s_ba = ba; s_aec = aec; s_stall = cpu_stall; s_own = owner;
    @(negedge clk);
    #1 ptr_req = 1'b0; obj_req = 1'b0;
  endtask

  initial begin
    int n_ba, n_aec, first_steal, f0, r0;
    repeat (3) @(negedge clk);
    check("R11", int'(phi), 0, "reset phi");
    check("R11", int'(ba), 1, "reset ba");
    check("R11", int'(aec), 0, "reset aec");
    check("R11", int'(cpu_stall), 0, "reset stall");
    check("R11", int'(owner), 0, "reset owner");
    #1 rst = 1'b0;

    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, i % 2);
      check("R2", int'(s_aec), 1, "idle high-phase aec");
      check("R2", int'(s_stall), 0, "idle stall");
      check("R2", int'(s_own), 1, "idle owner");
    end
    @(negedge clk);
    if (!phi) begin
      check("R1", int'(aec), 0, "video phase aec");
      check("R1", int'(cpu_stall), 0, "video phase stall");
    end

    // object fetch with write, read, write in the warning
    cyc(0, 1, 0);
    check("R2", int'(s_ba), 1, "ba in request cycle");
    cyc(0, 0, 0);
    check("R3", int'(s_ba), 0, "warning ba");
    check("R6", int'(s_aec), 1, "warning write aec");
    check("R6", int'(s_stall), 0, "warning write stall");
    check("R6", int'(s_own), 2, "warning owner");
    cyc(0, 0, 1);
    check("R6", int'(s_stall), 1, "warning read stalls");
    check("R6", int'(s_aec), 1, "warning read keeps aec");
    cyc(0, 0, 0);
    check("R6", int'(s_stall), 1, "stall sticky after read");
    for (int i = 0; i < 2; i++) begin
      cyc(0, 0, 1);
      check("R5", int'(s_aec), 0, "object stolen aec");
      check("R7", int'(s_stall), 1, "stolen stall");
      check("R7", int'(s_own), 0, "stolen owner");
    end
    cyc(0, 0, 1);
    check("R8", int'(s_ba), 1, "ba released");
    check("R8", int'(s_aec), 1, "aec released");
    check("R8", int'(s_stall), 0, "stall released");

    // pointer burst
    cyc(1, 0, 1);
    n_ba = 0; n_aec = 0; first_steal = -1;
    for (int i = 0; i < 50; i++) begin
      cyc(0, 0, 1);
      if (!s_ba) n_ba++;
      if (!s_aec) begin n_aec++; if (first_steal < 0) first_steal = i; end
    end
    check("R4", n_aec, 40, "pointer stolen cycles");
    check("R4", n_ba, 43, "pointer ba-low cycles");
    check("R3", first_steal, 3, "first stolen cycle offset");

    // merge: object request during pointer warning
    f0 = ba_falls;
    cyc(1, 0, 1);
    n_ba = 0; n_aec = 0;
    cyc(0, 0, 1); if (!s_ba) n_ba++; if (!s_aec) n_aec++;
    cyc(0, 1, 1); if (!s_ba) n_ba++; if (!s_aec) n_aec++;
    for (int i = 0; i < 60; i++) begin
      cyc(0, 0, 1);
      if (!s_ba) n_ba++;
      if (!s_aec) n_aec++;
    end
    check("R9", n_aec, 42, "merged stolen cycles");
    check("R9", n_ba, 45, "merged ba-low cycles");
    check("R9", ba_falls - f0, 1, "single ba fall");

    // both requests on one edge
    cyc(1, 1, 0);
    n_aec = 0;
    for (int i = 0; i < 60; i++) begin
      cyc(0, 0, 0);
      if (!s_aec) n_aec++;
    end
    check("R5", n_aec, 42, "joint request stolen cycles");

    // refresh over whole lines
    for (int l = 0; l < 2; l++) begin
      r0 = ref_seen;
      for (int i = 0; i < 63; i++) cyc(0, 0, 1);
      check("R10", ref_seen - r0, 5, "refresh slots per line");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule